// File: doc/BRIEF.md
# Battery fast-charge control state machine

This block sequences the charging of a nickel-cadmium or nickel-metal-hydride cell. It takes pre-digitised comparator flags (cell voltage low, cell voltage at maximum, temperature too hot to start, temperature cutoff, power-down), a decoded three-level rate select, an inhibit input and a termination request from an external voltage-slope detector. From these it drives a charge-enable output and a status-indicator output. Every time base inside the block is counted in ticks of a 1 ms enable input, and every limit is a parameter so that a bench can shrink it.

After reset, the block qualifies the cell. A qualified cell goes straight into fast charge. An unqualified cell waits in a pending state, where it receives pulse-trickle and the indicator flashes. Fast charge ends on a slope request once the hold-off window has passed, or on maximum voltage, temperature cutoff, or expiry of the safety timer. After that the cell gets pulse-trickle with the indicator off. A fall of the maximum-voltage flag starts a new cycle. The rate select sets the safety time, the hold-off window and the trickle pulse width together.

Top module: `chg_ctrl_fsm`

## Requirements
- R1: Reset puts the block in the pending state (indicator lit, flasher and trickle phases at zero). A qualified cell then enters fast charge on the next clock. An unqualified cell stays pending until it qualifies.
- R2: The pending state goes to fast charge only when cell_low_i, cell_max_i and temp_hot_i are all 0 and inhibit_i is 0.
- R3: In fast charge, ind_on_o is 1. chg_en_o is 1 unless inhibit_i is 1.
- R4: A fast charge that ends goes to the complete state. In the complete state, chg_en_o follows the trickle pulse and ind_on_o is 0. cell_max_i = 1 forces the complete state from any state except power-down.
- R5: A slope request is ignored until the hold-off window has elapsed. cell_max_i and temp_cut_i terminate fast charge at any point in the window.
- R6: mode_i encoding is 00 = low, 01 = mid, 10 = high, and 11 acts as mid. The safety limit is SAFE_BASE_TICKS × 2 for low, × 4 for mid and × 1 for high. The hold-off window is HOLD_BASE_TICKS scaled by the same factor. Both count fast-charge ticks from entry to fast charge, and fast charge ends on the tick that reaches the limit.
- R7: The pulse-trickle generator runs free with a period of TRICKLE_PERIOD ticks. In every period it is high for TRICKLE_W_LOW, TRICKLE_W_MID or TRICKLE_W_HIGH ticks, according to mode_i.
- R8: In the pending state, ind_on_o is 1 for the first FLASH_HALF ticks after entry and 0 for the next FLASH_HALF ticks, and this repeats.
- R9: While inhibit_i is 1 in fast charge, the safety and hold-off count is frozen, slope requests and expiry are ignored, ind_on_o stays 1 and chg_en_o follows the trickle pulse. temp_cut_i still terminates. When inhibit_i returns to 0, the count resumes from the frozen value.
- R10: pwr_dn_i = 1 puts the block in power-down from the next clock, with chg_en_o and ind_on_o both 0. When pwr_dn_i clears, the block goes to the complete state.
- R11: In the complete state, a 1-to-0 change of cell_max_i starts a new cycle through the pending state. Clearing temp_cut_i does not start a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms time-base enable |
| mode_i | input | 2 | Rate select: 00 low, 01 mid, 10 high |
| cell_low_i | input | 1 | Cell voltage at or below the low limit |
| cell_max_i | input | 1 | Cell voltage at or above the maximum |
| temp_hot_i | input | 1 | Temperature too hot to start fast charge |
| temp_cut_i | input | 1 | Temperature past the cutoff |
| pwr_dn_i | input | 1 | Power-down request |
| inhibit_i | input | 1 | Suspend fast charge |
| slope_term_i | input | 1 | Termination request from the slope detector |
| chg_en_o | output | 1 | 1 = charge current enabled |
| ind_on_o | output | 1 | 1 = status indicator lit |

## Verification
The inhibit input and a fast-charge termination can arrive in the same cycle. The bench provokes this by raising a slope request while inhibited after the hold-off window has passed. It judges that the indicator stays lit, that the trickle duty appears, and that the safety limit is still reached exactly the right number of un-inhibited ticks after entry. The hold-off boundary and a slope request also coincide: with the request held high from entry, the bench sweeps the three rates and requires the indicator to be lit one tick before the computed window end and dark on the tick that ends it.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    ST_PEND = 2'd0,
    ST_FAST = 2'd1,
    ST_DONE = 2'd2,
    ST_PDN  = 2'd3
  } chg_state_e;

  localparam logic [1:0] MODE_LOW  = 2'b00;
  localparam logic [1:0] MODE_MID  = 2'b01;
  localparam logic [1:0] MODE_HIGH = 2'b10;

  // limit multiplier as a shift: high x1, low x2, mid (and 11) x4
  function automatic logic [1:0] mode_shift(input logic [1:0] m);
    case (m)
      MODE_HIGH: return 2'd0;
      MODE_LOW:  return 2'd1;
      default:   return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chg_trickle_gen.sv
module chg_trickle_gen #(
  parameter int PERIOD = 1000,
  parameter int W_LOW  = 37,
  parameter int W_MID  = 73,
  parameter int W_HIGH = 18
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  output logic       pulse_o
);
  import chg_pkg::*;
  localparam int TW = $clog2(PERIOD);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] wid;

  always_comb begin
    case (mode_i)
      MODE_LOW:  wid = TW'(W_LOW);
      MODE_HIGH: wid = TW'(W_HIGH);
      default:   wid = TW'(W_MID);
    endcase
  end

  assign pulse_o = (cnt_q < wid);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == TW'(PERIOD - 1)) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chg_flasher.sv
module chg_flasher #(
  parameter int HALF = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic lit_o
);
  localparam int CW = $clog2(2 * HALF);

  logic [CW-1:0] cnt_q;

  assign lit_o = (cnt_q < CW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i) begin
      if (cnt_q == CW'(2 * HALF - 1)) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chg_ctrl_fsm.sv
module chg_ctrl_fsm #(
  parameter int SAFE_BASE_TICKS = 2400000,
  parameter int HOLD_BASE_TICKS = 75000,
  parameter int TRICKLE_PERIOD  = 1000,
  parameter int TRICKLE_W_LOW   = 37,
  parameter int TRICKLE_W_MID   = 73,
  parameter int TRICKLE_W_HIGH  = 18,
  parameter int FLASH_HALF      = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       cell_low_i,
  input  logic       cell_max_i,
  input  logic       temp_hot_i,
  input  logic       temp_cut_i,
  input  logic       pwr_dn_i,
  input  logic       inhibit_i,
  input  logic       slope_term_i,
  output logic       chg_en_o,
  output logic       ind_on_o
);
  import chg_pkg::*;

  localparam int SAFE_W = $clog2(SAFE_BASE_TICKS * 4 + 1);

  chg_state_e  state_q, state_d;
  logic        max_q;
  logic        max_fall;
  logic        qualified;
  logic [1:0]  shamt;
  logic [SAFE_W-1:0] safe_lim, hold_lim, elapsed;
  logic        safe_done, hold_done;
  logic        trickle;
  logic        flash_lit;
  logic        in_fast, in_pend;

  assign in_fast   = (state_q == ST_FAST);
  assign in_pend   = (state_q == ST_PEND);
  assign shamt     = mode_shift(mode_i);
  assign safe_lim  = SAFE_W'(SAFE_BASE_TICKS) << shamt;
  assign hold_lim  = SAFE_W'(HOLD_BASE_TICKS) << shamt;
  assign qualified = !cell_low_i && !cell_max_i && !temp_hot_i;
  assign max_fall  = max_q && !cell_max_i;

  // one elapsed-time counter serves both the safety limit and the hold-off window
  chg_tick_timer #(.W(SAFE_W)) u_elapsed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!in_fast),
    .run_i   (tick_i && in_fast && !inhibit_i),
    .limit_i (safe_lim),
    .cnt_o   (elapsed),
    .done_o  (safe_done)
  );

  assign hold_done = (elapsed >= hold_lim);

  chg_trickle_gen #(
    .PERIOD (TRICKLE_PERIOD),
    .W_LOW  (TRICKLE_W_LOW),
    .W_MID  (TRICKLE_W_MID),
    .W_HIGH (TRICKLE_W_HIGH)
  ) u_trickle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .mode_i  (mode_i),
    .pulse_o (trickle)
  );

  chg_flasher #(.HALF(FLASH_HALF)) u_flash (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!in_pend),
    .run_i   (tick_i && !inhibit_i),
    .lit_o   (flash_lit)
  );

  always_comb begin
    state_d = state_q;
    if (pwr_dn_i) begin
      state_d = ST_PDN;
    end else if (state_q == ST_PDN) begin
      state_d = ST_DONE;
    end else if (cell_max_i) begin
      state_d = ST_DONE;
    end else begin
      case (state_q)
        ST_PEND: if (!inhibit_i && qualified) state_d = ST_FAST;
        ST_FAST: begin
          if (temp_cut_i)
            state_d = ST_DONE;
          else if (!inhibit_i && (safe_done || (hold_done && slope_term_i)))
            state_d = ST_DONE;
        end
        ST_DONE: if (max_fall) state_d = ST_PEND;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PEND;
      max_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      max_q   <= cell_max_i;
    end
  end

  always_comb begin
    case (state_q)
      ST_FAST: begin
        chg_en_o = inhibit_i ? trickle : 1'b1;
        ind_on_o = 1'b1;
      end
      ST_PEND: begin
        chg_en_o = trickle;
        ind_on_o = flash_lit;
      end
      ST_DONE: begin
        chg_en_o = trickle;
        ind_on_o = 1'b0;
      end
      default: begin
        chg_en_o = 1'b0;
        ind_on_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/chg_ctrl_fsm_chk.sv
module chg_ctrl_fsm_chk #(
  parameter int ELAPSED_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cell_low_i,
  input logic                 cell_max_i,
  input logic                 temp_hot_i,
  input logic                 temp_cut_i,
  input logic                 pwr_dn_i,
  input logic                 inhibit_i,
  input logic                 chg_en_o,
  input logic                 ind_on_o,
  input chg_pkg::chg_state_e  state_i,
  input logic                 hold_done_i,
  input logic                 safe_done_i,
  input logic [ELAPSED_W-1:0] elapsed_i
);
  import chg_pkg::*;

  AST_FAST_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FAST |-> ind_on_o); // R3

  AST_PEND_NEEDS_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PEND && (cell_low_i || temp_hot_i)) |=> state_i != ST_FAST); // R2

  AST_MAX_ENDS_CHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_max_i && !pwr_dn_i) |=> !ind_on_o); // R4

  AST_HOLD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FAST && !hold_done_i && !safe_done_i && !cell_max_i &&
     !temp_cut_i && !pwr_dn_i) |=> state_i == ST_FAST); // R5

  AST_INH_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && state_i == ST_FAST) |=> $stable(elapsed_i)); // R9

  AST_PDN_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> (!chg_en_o && !ind_on_o)); // R10
endmodule

bind chg_ctrl_fsm chg_ctrl_fsm_chk #(.ELAPSED_W(SAFE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cell_low_i  (cell_low_i),
  .cell_max_i  (cell_max_i),
  .temp_hot_i  (temp_hot_i),
  .temp_cut_i  (temp_cut_i),
  .pwr_dn_i    (pwr_dn_i),
  .inhibit_i   (inhibit_i),
  .chg_en_o    (chg_en_o),
  .ind_on_o    (ind_on_o),
  .state_i     (state_q),
  .hold_done_i (hold_done),
  .safe_done_i (safe_done),
  .elapsed_i   (elapsed)
);

// File: tb/chg_ctrl_fsm_tb.sv
`timescale 1ns/1ps
module chg_ctrl_fsm_tb;
  localparam int SAFE_B = 40;
  localparam int HOLD_B = 10;
  localparam int PER    = 20;
  localparam int WL     = 4;
  localparam int WM     = 7;
  localparam int WH     = 2;
  localparam int HALF   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] mode = 2'b10;
  logic cell_low = 1'b0, cell_max = 1'b0, temp_hot = 1'b0, temp_cut = 1'b0;
  logic pwr_dn = 1'b0, inhibit = 1'b0, slope = 1'b0;
  logic chg_en, ind_on;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  chg_ctrl_fsm #(
    .SAFE_BASE_TICKS (SAFE_B),
    .HOLD_BASE_TICKS (HOLD_B),
    .TRICKLE_PERIOD  (PER),
    .TRICKLE_W_LOW   (WL),
    .TRICKLE_W_MID   (WM),
    .TRICKLE_W_HIGH  (WH),
    .FLASH_HALF      (HALF)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .mode_i (mode),
    .cell_low_i (cell_low), .cell_max_i (cell_max), .temp_hot_i (temp_hot),
    .temp_cut_i (temp_cut), .pwr_dn_i (pwr_dn), .inhibit_i (inhibit),
    .slope_term_i (slope), .chg_en_o (chg_en), .ind_on_o (ind_on)
  );

  function automatic int mult(input logic [1:0] m);
    case (m)
      2'b10:   return 1;
      2'b00:   return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int wid(input logic [1:0] m);
    case (m)
      2'b10:   return WH;
      2'b00:   return WL;
      default: return WM;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
  endtask

  // one tick, then wait until the FSM has reacted
  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      cyc(2);
    end
  endtask

  task automatic ticks_count(input int n, output int en_hi, output int ind_hi);
    en_hi = 0;
    ind_hi = 0;
    repeat (n) begin
      ticks(1);
      en_hi += int'(chg_en);
      ind_hi += int'(ind_on);
    end
  endtask

  initial begin
    #(10ns * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int e, l;
    logic [1:0] modes [3];
    modes[0] = 2'b00; modes[1] = 2'b01; modes[2] = 2'b10;

    // R1: reset state is pending with both phases at zero
    cell_low = 1'b1;
    cyc(2);
    chk("R1 reset ind", int'(ind_on), 1);
    chk("R1 reset en", int'(chg_en), 1);
    rst_n = 1'b1;
    cyc(2);

    // R8: flash pattern in pending
    for (int k = 1; k <= 4 * HALF; k++) begin
      ticks(1);
      chk($sformatf("R8 flash k=%0d", k), int'(ind_on), ((k % (2 * HALF)) < HALF) ? 1 : 0);
    end

    // R2: qualification sweep (mode high, 5 ticks after reset)
    for (int c = 0; c < 4; c++) begin
      mode = 2'b10;
      cell_low = c[0];
      temp_hot = c[1];
      do_reset();
      ticks(5);
      chk($sformatf("R2 qual c=%0d ind", c), int'(ind_on), (c == 0) ? 1 : 0);
      chk($sformatf("R2 qual c=%0d en", c), int'(chg_en), (c == 0) ? 1 : 0);
      cell_low = 1'b0;
      temp_hot = 1'b0;
      cyc(2);
      chk($sformatf("R1 qualify later c=%0d", c), int'(ind_on & chg_en), 1);
    end

    // R6 safety limit, then R4/R7 complete-state trickle per mode
    foreach (modes[i]) begin
      mode = modes[i];
      slope = 1'b0;
      do_reset();
      ticks(SAFE_B * mult(mode) - 1);
      chk($sformatf("R6 safe m=%0d before", mode), int'(ind_on), 1);
      ticks(1);
      chk($sformatf("R6 safe m=%0d at limit", mode), int'(ind_on), 0);
      ticks_count(PER, e, l);
      chk($sformatf("R7 duty m=%0d", mode), e, wid(mode));
      chk($sformatf("R4 done ind m=%0d", mode), l, 0);
    end

    // R5/R6 hold-off with slope held from entry
    foreach (modes[i]) begin
      mode = modes[i];
      slope = 1'b1;
      do_reset();
      ticks(HOLD_B * mult(mode) - 1);
      chk($sformatf("R5 hold m=%0d masked", mode), int'(ind_on), 1);
      ticks(1);
      chk($sformatf("R6 hold m=%0d end", mode), int'(ind_on), 0);
    end
    slope = 1'b0;

    // R5/R4: max voltage inside hold-off, then R11 new cycle
    mode = 2'b10;
    do_reset();
    ticks(2);
    cell_max = 1'b1;
    cyc(2);
    chk("R5 max in hold", int'(ind_on), 0);
    ticks_count(PER, e, l);
    chk("R4 max done duty", e, WH);
    cell_max = 1'b0;
    cyc(3);
    chk("R11 new cycle ind", int'(ind_on), 1);
    chk("R11 new cycle en", int'(chg_en), 1);

    // R5: cutoff inside hold-off; clearing it starts no new cycle (R11)
    do_reset();
    ticks(2);
    temp_cut = 1'b1;
    cyc(2);
    chk("R5 cut in hold", int'(ind_on), 0);
    temp_cut = 1'b0;
    ticks_count(6, e, l);
    chk("R11 no restart on cut clear", l, 0);

    // R9: inhibit with concurrent slope request after hold-off
    do_reset();
    ticks(20);
    inhibit = 1'b1;
    slope = 1'b1;
    cyc(1);
    ticks_count(2 * PER, e, l);
    chk("R9 inh duty", e, 2 * WH);
    chk("R9 inh ind", l, 2 * PER);
    slope = 1'b0;
    inhibit = 1'b0;
    cyc(1);
    ticks(SAFE_B - 20 - 1);
    chk("R9 resumed before limit", int'(ind_on), 1);
    ticks(1);
    chk("R9 resumed at limit", int'(ind_on), 0);

    // R9: cutoff still terminates under inhibit
    do_reset();
    inhibit = 1'b1;
    temp_cut = 1'b1;
    cyc(2);
    chk("R9 cut under inhibit", int'(ind_on), 0);
    inhibit = 1'b0;
    temp_cut = 1'b0;

    // R10: power-down then complete state
    do_reset();
    pwr_dn = 1'b1;
    cyc(1);
    ticks_count(PER, e, l);
    chk("R10 pdn en", e, 0);
    chk("R10 pdn ind", l, 0);
    pwr_dn = 1'b0;
    cyc(2);
    ticks_count(PER, e, l);
    chk("R10 after pdn duty", e, WH);
    chk("R10 after pdn ind", l, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule